// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the memory accesses of a processor core and flags the ones that fall on a programmed breakpoint. It holds four breakpoint addresses, a control word and a sticky status word. In every cycle an access strobe may arrive with an address, a size code and a kind: instruction fetch, data write or data read. Each enabled breakpoint compares its own aligned region against the access. When a breakpoint hits, its status bit is set and a one-cycle debug request is raised for the exception logic.

The same status word also records three other causes: single-step traps, task switches into a task whose trap bit is set, and faults raised by a debug-register access while general-detect protection is armed. A resume flag, armed by the core, hides instruction-fetch breakpoints for the next fetch only. A task switch drops every task-local enable and keeps the global ones. Exception delivery and the pipeline are outside the block.

Top module: `dbg_watch_unit`

## Requirements
- R1: A data breakpoint covers an aligned region selected by its 2-bit length code (00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes, low address bits masked). An access is also an aligned region, set by its size code (00 = 1, 01 = 2, 11 or 10 = 4 bytes). The breakpoint matches when the two regions overlap.
- R2: The 2-bit type field of each breakpoint selects what triggers it. 00 is a fetch at exactly the breakpoint address, whatever the length code. 01 is a data write. 11 is a data read or write. 10 never matches, and a data breakpoint whose length code is 10 never matches. Access kind codes are 00 = fetch, 01 = write, 10 = read.
- R3: Breakpoint i is active only while its local enable (control bit 2i) or its global enable (control bit 2i+1) is set. No match happens without the access valid strobe. The type field of breakpoint i sits at control bits 16+4i..17+4i and its length field at bits 18+4i..19+4i.
- R4: Status bits 0..3 (breakpoints), 13 (access fault), 14 (single step) and 15 (task-switch trap) are sticky. They accumulate until software writes the status word, and a write replaces them with the written value masked to those bits.
- R5: `dbg_req` is high for one cycle, in the cycle after any cause is detected, and stays low otherwise.
- R6: A pulse on `resume_set` arms a resume flag. While it is armed, the next valid fetch sets no breakpoint bit. That fetch then disarms it, so the fetch after it matches normally.
- R7: A task switch clears the local enables and the local exact bit (control bit 8). It keeps the global enables and the global exact bit (bit 9). With `task_trap` high it also sets status bit 15.
- R8: A `single_step` pulse sets status bit 14.
- R9: While general detect (control bit 13) is set, any register access has no effect. It pulses `reg_fault`, sets status bit 13 and clears general detect.
- R10: After reset the addresses, control, status, `dbg_req` and `reg_fault` are all zero.
- R11: Register select 0..3 addresses the breakpoints, 4 the control word and 5 the status word. A legal read returns the value on `reg_rdata` one cycle later. Control bits outside the defined fields read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after a legal read |
| reg_fault | output | 1 | Access refused under general detect |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 2 | Access kind code |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code |
| resume_set | input | 1 | Arms the resume flag |
| single_step | input | 1 | Single-step trap event |
| task_switch | input | 1 | Task switch event |
| task_trap | input | 1 | Trap bit of the incoming task |
| dbg_req | output | 1 | Debug exception request |

## Verification
The assertions check on every cycle that each request pulse follows a cause, that sticky bits fall only through a status write, and that a refused access always comes with its status bit and a request. They also check that a task switch leaves no local enable behind, that a single step always leaves its mark, and that a fetch under the resume flag disarms it. Only the bench scenarios can show the region and type decoding, the accumulation of several causes, and the read-back values. They also show the effects that must be absent: the suppressed fetch, the undefined codes, a disabled breakpoint, and the write that is lost under protection.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_READ  = 2'b10
  } acc_kind_e;

  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam int CTL_LEXACT = 8;
  localparam int CTL_GEXACT = 9;
  localparam int CTL_GDET   = 13;
  localparam int CTL_FIELD0 = 16;

  localparam int ST_BD = 13;
  localparam int ST_BS = 14;
  localparam int ST_BT = 15;

  function automatic logic [1:0] size_mask(input logic [1:0] code);
    case (code)
      2'b00:   size_mask = 2'b00;
      2'b01:   size_mask = 2'b01;
      default: size_mask = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/dbgw_slot.sv
module dbgw_slot
  import dbgw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] bp_addr,
  input  logic            en,
  input  logic [1:0]      rw,
  input  logic [1:0]      len,
  input  logic            acc_valid,
  input  acc_kind_e       acc_kind,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            hide_fetch,
  output logic            hit
);
  logic [XLEN-1:0] mask;
  logic            kind_ok;

  always_comb begin
    hit     = 1'b0;
    mask    = '0;
    kind_ok = 1'b0;
    if (acc_valid && en) begin
      case (rw)
        2'b00: hit = (acc_kind == KIND_FETCH) && !hide_fetch && (acc_addr == bp_addr);
        2'b01, 2'b11: begin
          kind_ok = (acc_kind == KIND_WRITE) || (rw == 2'b11 && acc_kind == KIND_READ);
          mask[1:0] = size_mask(len) | size_mask(acc_size);
          hit = kind_ok && (len != 2'b10) && (((acc_addr ^ bp_addr) & ~mask) == '0);
        end
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dbgw_status.sv
module dbgw_status
  import dbgw_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BP-1:0] hits,
  input  logic              step_ev,
  input  logic              trap_ev,
  input  logic              fault_ev,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   status_q,
  output logic              dbg_req
);
  localparam logic [XLEN-1:0] STAT_MASK =
    (XLEN'(1) << ST_BD) | (XLEN'(1) << ST_BS) | (XLEN'(1) << ST_BT) |
    ((XLEN'(1) << NUM_BP) - XLEN'(1));

  logic [XLEN-1:0] set_v;
  logic [XLEN-1:0] base_v;

  always_comb begin
    set_v             = '0;
    set_v[NUM_BP-1:0] = hits;
    set_v[ST_BD]      = fault_ev;
    set_v[ST_BS]      = step_ev;
    set_v[ST_BT]      = trap_ev;
    base_v            = we ? (wdata & STAT_MASK) : status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      dbg_req  <= 1'b0;
    end else begin
      status_q <= base_v | set_v;
      dbg_req  <= |set_v;
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbgw_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_BP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_req,
  input  logic            reg_wr,
  input  logic [2:0]      reg_sel,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  output logic            reg_fault,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            resume_set,
  input  logic            single_step,
  input  logic            task_switch,
  input  logic            task_trap,
  output logic            dbg_req
);
  localparam int IDX_W = $clog2(NUM_BP);

  localparam logic [XLEN-1:0] EN_MASK    = (XLEN'(1) << (2 * NUM_BP)) - XLEN'(1);
  localparam logic [XLEN-1:0] FIELD_MASK = ((XLEN'(1) << (4 * NUM_BP)) - XLEN'(1)) << CTL_FIELD0;
  localparam logic [XLEN-1:0] CTRL_MASK  = EN_MASK | FIELD_MASK | (XLEN'(1) << CTL_LEXACT) |
                                           (XLEN'(1) << CTL_GEXACT) | (XLEN'(1) << CTL_GDET);

  logic [XLEN-1:0] bp_addr_q [NUM_BP];
  logic [XLEN-1:0] ctrl_q, ctrl_n;
  logic [XLEN-1:0] status_q;
  logic            rf_q;
  logic            legal, fault_ev, wr_ok, stat_we, fetch_seen;
  logic [NUM_BP-1:0] hits;
  acc_kind_e       kind;

  assign kind       = acc_kind_e'(acc_kind);
  assign fault_ev   = reg_req && ctrl_q[CTL_GDET];
  assign legal      = reg_req && !ctrl_q[CTL_GDET];
  assign wr_ok      = legal && reg_wr;
  assign stat_we    = wr_ok && (reg_sel == SEL_STAT);
  assign fetch_seen = acc_valid && (kind == KIND_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BP; i++) bp_addr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_BP; i++)
        if (wr_ok && reg_sel == 3'(i)) bp_addr_q[i] <= reg_wdata;
    end
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ok && reg_sel == SEL_CTRL) ctrl_n = reg_wdata & CTRL_MASK;
    if (fault_ev) ctrl_n[CTL_GDET] = 1'b0;
    if (task_switch) begin
      for (int i = 0; i < NUM_BP; i++) ctrl_n[2*i] = 1'b0;
      ctrl_n[CTL_LEXACT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      rf_q      <= 1'b0;
      reg_rdata <= '0;
      reg_fault <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_n;
      reg_fault <= fault_ev;
      if (resume_set)      rf_q <= 1'b1;
      else if (fetch_seen) rf_q <= 1'b0;
      if (legal && !reg_wr) begin
        if (reg_sel == SEL_CTRL)       reg_rdata <= ctrl_q;
        else if (reg_sel == SEL_STAT)  reg_rdata <= status_q;
        else if (reg_sel < 3'(NUM_BP)) reg_rdata <= bp_addr_q[reg_sel[IDX_W-1:0]];
        else                           reg_rdata <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
    dbgw_slot #(.XLEN(XLEN)) u_slot (
      .bp_addr   (bp_addr_q[g]),
      .en        (ctrl_q[2*g] | ctrl_q[2*g+1]),
      .rw        (ctrl_q[CTL_FIELD0+4*g +: 2]),
      .len       (ctrl_q[CTL_FIELD0+4*g+2 +: 2]),
      .acc_valid (acc_valid),
      .acc_kind  (kind),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .hide_fetch(rf_q),
      .hit       (hits[g])
    );
  end

  dbgw_status #(.XLEN(XLEN), .NUM_BP(NUM_BP)) u_status (
    .clk     (clk),
    .rst     (rst),
    .hits    (hits),
    .step_ev (single_step),
    .trap_ev (task_switch && task_trap),
    .fault_ev(fault_ev),
    .we      (stat_we),
    .wdata   (reg_wdata),
    .status_q(status_q),
    .dbg_req (dbg_req)
  );
endmodule

// File: rtl/dbgw_checker.sv
module dbgw_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_req,
  input logic        reg_fault,
  input logic        acc_valid,
  input logic [1:0]  acc_kind,
  input logic        resume_set,
  input logic        single_step,
  input logic        task_switch,
  input logic        task_trap,
  input logic        dbg_req,
  input logic [31:0] status_q,
  input logic [31:0] ctrl_q,
  input logic        stat_we,
  input logic        rf_q
);
  assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> $past(acc_valid || single_step || (task_switch && task_trap) || reg_req));

  assert_sticky_bits_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(stat_we) |-> ((status_q & $past(status_q)) == $past(status_q)));

  assert_fault_marks_R9: assert property (@(posedge clk) disable iff (rst)
    reg_fault |-> (status_q[13] && dbg_req && !ctrl_q[13]));

  assert_locals_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    $past(task_switch) |-> (ctrl_q[0] == 1'b0 && ctrl_q[2] == 1'b0 &&
                            ctrl_q[4] == 1'b0 && ctrl_q[6] == 1'b0 && ctrl_q[8] == 1'b0));

  assert_step_marks_R8: assert property (@(posedge clk) disable iff (rst)
    $past(single_step) |-> (status_q[14] && dbg_req));

  assert_resume_consumed_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rf_q && acc_valid && acc_kind == 2'b00 && !resume_set) |-> !rf_q);
endmodule

bind dbg_watch_unit dbgw_checker u_dbgw_checker (
  .clk        (clk),
  .rst        (rst),
  .reg_req    (reg_req),
  .reg_fault  (reg_fault),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .resume_set (resume_set),
  .single_step(single_step),
  .task_switch(task_switch),
  .task_trap  (task_trap),
  .dbg_req    (dbg_req),
  .status_q   (status_q),
  .ctrl_q     (ctrl_q),
  .stat_we    (stat_we),
  .rf_q       (rf_q)
);

// File: tb/test_dbg_watch_unit.sv
module test_dbg_watch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_fault;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0, acc_size = '0;
  logic [31:0] acc_addr = '0;
  logic        resume_set = 1'b0, single_step = 1'b0, task_switch = 1'b0, task_trap = 1'b0;
  logic        dbg_req;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  dbg_watch_unit i_dbg_watch_unit (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_fault(reg_fault),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
    .resume_set(resume_set), .single_step(single_step), .task_switch(task_switch),
    .task_trap(task_trap), .dbg_req(dbg_req)
  );

  // {valid, kind, size, addr, expected request, expected status}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 32'h0000_1000, 1'b1, 4'h1},
    {1'b1, 2'd0, 2'd0, 32'h0000_1001, 1'b0, 4'h0},
    {1'b1, 2'd2, 2'd0, 32'h0000_1000, 1'b0, 4'h0},
    {1'b1, 2'd1, 2'd0, 32'h0000_2006, 1'b1, 4'h2},
    {1'b1, 2'd2, 2'd3, 32'h0000_2004, 1'b0, 4'h0},
    {1'b1, 2'd1, 2'd3, 32'h0000_2000, 1'b0, 4'h0},
    {1'b1, 2'd2, 2'd0, 32'h0000_3003, 1'b1, 4'h4},
    {1'b1, 2'd1, 2'd3, 32'h0000_3000, 1'b1, 4'h4},
    {1'b1, 2'd2, 2'd0, 32'h0000_3004, 1'b0, 4'h0},
    {1'b1, 2'd1, 2'd0, 32'h0000_4000, 1'b0, 4'h0},
    {1'b1, 2'd0, 2'd0, 32'h0000_3002, 1'b0, 4'h0},
    {1'b0, 2'd0, 2'd0, 32'h0000_1000, 1'b0, 4'h0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_sel = sel;
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic access(input logic v, input logic [1:0] k, input logic [1:0] s, input logic [31:0] a);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_size = s; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 dbg_req", {31'd0, dbg_req}, 32'd0);
    check("R10 reg_fault", {31'd0, reg_fault}, 32'd0);
    reg_read(3'd4, rd); check("R10 ctrl", rd, 32'd0);
    reg_read(3'd5, rd); check("R10 status", rd, 32'd0);
    reg_read(3'd0, rd); check("R10 bp0", rd, 32'd0);
    // R11: undefined control bits read as zero
    reg_write(3'd4, 32'hFFFF_DFFF);
    reg_read(3'd4, rd); check("R11 ctrl mask", rd, 32'hFFFF_03FF);
    // program breakpoints
    reg_write(3'd0, 32'h0000_1000);
    reg_write(3'd1, 32'h0000_2004);
    reg_write(3'd2, 32'h0000_3002);
    reg_write(3'd3, 32'h0000_4000);
    reg_write(3'd4, 32'h27D0_00A6);
    reg_read(3'd2, rd); check("R11 bp2 readback", rd, 32'h0000_3002);
    // R1 R2 R3 table
    for (int i = 0; i < NV; i++) begin
      reg_write(3'd5, 32'd0);
      access(VEC[i][41], VEC[i][40:39], VEC[i][38:37], VEC[i][36:5]);
      check($sformatf("R1/R2 vec%0d req", i), {31'd0, dbg_req}, {31'd0, VEC[i][4]});
      reg_read(3'd5, rd);
      check($sformatf("R1/R2 vec%0d status", i), rd, {28'd0, VEC[i][3:0]});
    end
    // R4: sticky accumulation and write replace
    reg_write(3'd5, 32'd0);
    access(1'b1, 2'd0, 2'd0, 32'h1000);
    access(1'b1, 2'd1, 2'd0, 32'h2004);
    reg_read(3'd5, rd); check("R4 accumulate", rd, 32'h3);
    reg_write(3'd5, 32'hFFFF_FFFF);
    reg_read(3'd5, rd); check("R4 write mask", rd, 32'h0000_E00F);
    reg_write(3'd5, 32'd0);
    // R6: resume flag hides one fetch
    @(negedge clk); resume_set = 1'b1;
    @(negedge clk); resume_set = 1'b0;
    access(1'b1, 2'd0, 2'd0, 32'h1000);
    check("R6 hidden req", {31'd0, dbg_req}, 32'd0);
    reg_read(3'd5, rd); check("R6 hidden status", rd, 32'd0);
    access(1'b1, 2'd0, 2'd0, 32'h1000);
    check("R6 next fetch req", {31'd0, dbg_req}, 32'd1);
    reg_read(3'd5, rd); check("R6 next fetch status", rd, 32'h1);
    reg_write(3'd5, 32'd0);
    // R2: length 10 never matches; R3: enable gating
    reg_write(3'd4, 32'h97D0_00A6);
    access(1'b1, 2'd1, 2'd0, 32'h4000);
    check("R2 len10 req", {31'd0, dbg_req}, 32'd0);
    reg_write(3'd4, 32'h17D0_00A6);
    access(1'b1, 2'd1, 2'd0, 32'h4000);
    reg_read(3'd5, rd); check("R3 bp3 enabled", rd, 32'h8);
    reg_write(3'd5, 32'd0);
    reg_write(3'd4, 32'h17D0_0026);
    access(1'b1, 2'd1, 2'd0, 32'h4000);
    check("R3 bp3 disabled", {31'd0, dbg_req}, 32'd0);
    // R7: task switch
    reg_write(3'd4, 32'h27D0_03A6);
    @(negedge clk); task_switch = 1'b1; task_trap = 1'b1;
    @(negedge clk); task_switch = 1'b0; task_trap = 1'b0;
    check("R7 trap req", {31'd0, dbg_req}, 32'd1);
    reg_read(3'd5, rd); check("R7 BT", rd, 32'h0000_8000);
    reg_read(3'd4, rd); check("R7 locals cleared", rd, 32'h27D0_02A2);
    reg_write(3'd5, 32'd0);
    access(1'b1, 2'd1, 2'd0, 32'h2004);
    check("R7 local bp off", {31'd0, dbg_req}, 32'd0);
    @(negedge clk); task_switch = 1'b1; task_trap = 1'b0;
    @(negedge clk); task_switch = 1'b0;
    check("R7 no trap req", {31'd0, dbg_req}, 32'd0);
    reg_read(3'd5, rd); check("R7 no trap status", rd, 32'd0);
    // R8: single step
    @(negedge clk); single_step = 1'b1;
    @(negedge clk); single_step = 1'b0;
    check("R8 step req", {31'd0, dbg_req}, 32'd1);
    @(negedge clk);
    check("R5 req one cycle", {31'd0, dbg_req}, 32'd0);
    reg_read(3'd5, rd); check("R8 BS", rd, 32'h0000_4000);
    reg_write(3'd5, 32'd0);
    // R9: general detect
    reg_write(3'd4, 32'h27D0_22A2);
    reg_write(3'd0, 32'h0000_DEAD);
    check("R9 fault", {31'd0, reg_fault}, 32'd1);
    check("R9 req", {31'd0, dbg_req}, 32'd1);
    reg_read(3'd0, rd); check("R9 write lost", rd, 32'h0000_1000);
    reg_read(3'd4, rd); check("R9 GD cleared", rd, 32'h27D0_02A2);
    reg_read(3'd5, rd); check("R9 BD", rd, 32'h0000_2000);
    finish_run();
  end
endmodule